// File: doc/BRIEF.md
# Region-Mapped Big-Endian Memory Port

This block sits between a processor's load/store logic and a local byte store. It takes one byte or word access at a time on a 16-bit address and decides, through a small table of address windows, which bytes of an internal byte array the access reaches. Each window has an inclusive low and high address, a base offset into the array, and separate read and write permission bits. Software or boot logic loads the windows one entry per cycle through a configuration port.

Word data is big-endian. The byte the access's offset points at forms the upper half of the word, and the next byte forms the lower half. Word accesses must be even. An odd word address does not split into two byte accesses. Instead it completes with a fault flag that the exception logic samples, and it returns all-ones or drops the write. Reads that reach no readable window return all-ones of the access width. Writes that reach no writable window do nothing. Every completed access adds a fixed cost to a running cycle total.

Top module: `regmap_mem_port`

## Requirements
- R1: A word access (reqWord=1) to an odd address completes with rspFault=1 during the rspDone cycle. A read returns 16'hFFFF, and a write changes no byte of the array. Every other access completes with rspFault=0.
- R2: Word data is big-endian. The byte at array offset k is rspRdata[15:8] or reqWdata[15:8], and the byte at offset k+1 is bits 7:0.
- R3: Windows are searched from index 0 upward. The access uses the first window whose range holds the address and that has the permission bit the access needs (cfgRead for reads, cfgWrite for writes). A window without that bit is skipped.
- R4: A window's range is inclusive at both ends: start <= address <= end.
- R5: A read with no matching readable window returns 16'hFFFF for a word and 16'h00FF for a byte.
- R6: A write with no matching writable window leaves every byte of the array unchanged.
- R7: A byte access may use any address. A byte read returns the byte in rspRdata[7:0] with bits 15:8 zero. A byte write stores reqWdata[7:0] into one byte only.
- R8: A request is accepted on a clock edge where reqValid and reqReady are both 1. rspDone is high for exactly the one cycle after the next edge, and reqReady is low from acceptance until rspDone has fallen.
- R9: cycleCount starts at zero after reset and grows by ACCESS_COST at the end of each rspDone cycle. This includes faulted and unmapped accesses.
- R10: The array offset is cfgBase + (address - start), taken modulo MEM_BYTES, which is a power of two. The second byte of a word is at that offset plus one, also modulo MEM_BYTES.
- R11: While cfgWe is 1, the window selected by cfgIdx takes cfgStart, cfgEnd, cfgBase, cfgRead and cfgWrite at the clock edge. Reset clears all permission bits, so every access is unmapped until windows are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Load one window entry |
| cfgIdx | input | $clog2(NUM_REGIONS) | Window index to load |
| cfgStart | input | 16 | Lowest address of the window |
| cfgEnd | input | 16 | Highest address of the window |
| cfgBase | input | $clog2(MEM_BYTES) | Array offset of the window start |
| cfgRead | input | 1 | Window allows reads |
| cfgWrite | input | 1 | Window allows writes |
| reqValid | input | 1 | Access request |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 16 | Write data (bits 7:0 for a byte write) |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read data, valid with rspDone |
| rspFault | output | 1 | Unaligned word access, valid with rspDone |
| cycleCount | output | COUNT_W | Running access cost total |

## Verification
The case that is hardest to reach from the ports is two windows that cover the same addresses but carry different permissions and bases. In that case a read and a write to one address land at different array offsets, and only a later read through another window can show where the write went. The stimulus first fills the whole array through one wide read-write window. It then builds directed overlapping windows and reads back through them. After that it reloads random overlapping, permission-mixed windows every few dozen accesses. A bench model of the array and the window table predicts every read.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch the incoming request
    logic commit;   // perform the lookup, write and read
    logic finish;   // completion cycle
  } rmpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2
  } rmpState_e;

endpackage

// File: rtl/rmp_ctrl.sv
module rmp_ctrl
  import rmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspDone,
  output rmpStrobe_t strobe
);

  rmpState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_ACCESS;
      ST_ACCESS: stateNext = ST_DONE;
      ST_DONE:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady       = (state == ST_IDLE);
  assign rspDone        = (state == ST_DONE);
  assign strobe.capture = reqReady && reqValid;
  assign strobe.commit  = (state == ST_ACCESS);
  assign strobe.finish  = rspDone;

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R8: an accepted request completes two edges later
  assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!rspDone && !reqReady) ##1 rspDone);

endmodule

// File: rtl/rmp_datapath.sv
module rmp_datapath
  import rmp_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int MEM_BYTES   = 1024,
  parameter int ACCESS_COST = 2,
  parameter int COUNT_W     = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  rmpStrobe_t                     strobe,
  input  logic                           cfgWe,
  input  logic [$clog2(NUM_REGIONS)-1:0] cfgIdx,
  input  logic [15:0]                    cfgStart,
  input  logic [15:0]                    cfgEnd,
  input  logic [$clog2(MEM_BYTES)-1:0]   cfgBase,
  input  logic                           cfgRead,
  input  logic                           cfgWrite,
  input  logic                           reqWrite,
  input  logic                           reqWord,
  input  logic [15:0]                    reqAddr,
  input  logic [15:0]                    reqWdata,
  output logic [15:0]                    rspRdata,
  output logic                           rspFault,
  output logic [COUNT_W-1:0]             cycleCount
);

  localparam int MEM_AW = $clog2(MEM_BYTES);

  // Window table
  logic [15:0]       winStart [NUM_REGIONS];
  logic [15:0]       winEnd   [NUM_REGIONS];
  logic [MEM_AW-1:0] winBase  [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] winRd, winWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winRd <= '0;
      winWr <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        winStart[i] <= '0;
        winEnd[i]   <= '0;
        winBase[i]  <= '0;
      end
    end else if (cfgWe) begin
      winStart[cfgIdx] <= cfgStart;
      winEnd[cfgIdx]   <= cfgEnd;
      winBase[cfgIdx]  <= cfgBase;
      winRd[cfgIdx]    <= cfgRead;
      winWr[cfgIdx]    <= cfgWrite;
    end
  end

  // Captured request
  logic        curWrite, curWord;
  logic [15:0] curAddr, curWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curWord  <= 1'b0;
      curAddr  <= '0;
      curWdata <= '0;
    end else if (strobe.capture) begin
      curWrite <= reqWrite;
      curWord  <= reqWord;
      curAddr  <= reqAddr;
      curWdata <= reqWdata;
    end
  end

  // Per-window hit and offset
  logic [NUM_REGIONS-1:0] winHit;
  logic [MEM_AW-1:0]      winOffs [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    logic [15:0] delta;
    logic        inRange;
    assign inRange   = (curAddr >= winStart[g]) && (curAddr <= winEnd[g]);
    assign winHit[g] = inRange && (curWrite ? winWr[g] : winRd[g]);
    assign delta     = curAddr - winStart[g];
    assign winOffs[g] = winBase[g] + delta[MEM_AW-1:0];
  end

  // First match wins: scan from the top so index 0 is assigned last
  logic              found;
  logic [MEM_AW-1:0] offHi, offLo;

  always_comb begin
    found = 1'b0;
    offHi = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (winHit[i]) begin
        found = 1'b1;
        offHi = winOffs[i];
      end
    end
    offLo = offHi + 1'b1;
  end

  logic misaligned;
  assign misaligned = curWord && curAddr[0];

  // Byte array, no reset
  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (strobe.commit && curWrite && found && !misaligned) begin
      if (curWord) begin
        mem[offHi] <= curWdata[15:8];
        mem[offLo] <= curWdata[7:0];
      end else begin
        mem[offHi] <= curWdata[7:0];
      end
    end
  end

  // Response registers
  logic [15:0]        rdataQ;
  logic               faultQ;
  logic [COUNT_W-1:0] countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      faultQ <= 1'b0;
    end else if (strobe.commit) begin
      faultQ <= misaligned;
      if (misaligned)       rdataQ <= 16'hFFFF;
      else if (curWrite)    rdataQ <= 16'h0000;
      else if (!found)      rdataQ <= curWord ? 16'hFFFF : 16'h00FF;
      else if (curWord)     rdataQ <= {mem[offHi], mem[offLo]};
      else                  rdataQ <= {8'h00, mem[offHi]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              countQ <= '0;
    else if (strobe.finish) countQ <= countQ + COUNT_W'(ACCESS_COST);
  end

  assign rspRdata   = rdataQ;
  assign rspFault   = faultQ && strobe.finish;
  assign cycleCount = countQ;

  // R1: a faulted completion always returns all-ones
  assert_fault_ones_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspRdata == 16'hFFFF));

  // R9: each completion advances the total by the access cost
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> (cycleCount == $past(cycleCount) + COUNT_W'(ACCESS_COST)));

  // R9: the total is frozen outside completion cycles
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(cycleCount));

endmodule

// File: rtl/regmap_mem_port.sv
module regmap_mem_port
  import rmp_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int MEM_BYTES   = 1024,
  parameter int ACCESS_COST = 2,
  parameter int COUNT_W     = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWe,
  input  logic [$clog2(NUM_REGIONS)-1:0] cfgIdx,
  input  logic [15:0]                    cfgStart,
  input  logic [15:0]                    cfgEnd,
  input  logic [$clog2(MEM_BYTES)-1:0]   cfgBase,
  input  logic                           cfgRead,
  input  logic                           cfgWrite,
  input  logic                           reqValid,
  output logic                           reqReady,
  input  logic                           reqWrite,
  input  logic                           reqWord,
  input  logic [15:0]                    reqAddr,
  input  logic [15:0]                    reqWdata,
  output logic                           rspDone,
  output logic [15:0]                    rspRdata,
  output logic                           rspFault,
  output logic [COUNT_W-1:0]             cycleCount
);

  rmpStrobe_t strobe;

  rmp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspDone  (rspDone),
    .strobe   (strobe)
  );

  rmp_datapath #(
    .NUM_REGIONS (NUM_REGIONS),
    .MEM_BYTES   (MEM_BYTES),
    .ACCESS_COST (ACCESS_COST),
    .COUNT_W     (COUNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWe      (cfgWe),
    .cfgIdx     (cfgIdx),
    .cfgStart   (cfgStart),
    .cfgEnd     (cfgEnd),
    .cfgBase    (cfgBase),
    .cfgRead    (cfgRead),
    .cfgWrite   (cfgWrite),
    .reqWrite   (reqWrite),
    .reqWord    (reqWord),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .rspRdata   (rspRdata),
    .rspFault   (rspFault),
    .cycleCount (cycleCount)
  );

endmodule

// File: tb/regmap_mem_port_bench.sv
module regmap_mem_port_bench;

  localparam int NR   = 4;
  localparam int MB   = 1024;
  localparam int COST = 2;
  localparam int CW   = 32;
  localparam int AW   = $clog2(MB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic                   cfgWe = 1'b0;
  logic [$clog2(NR)-1:0]  cfgIdx = '0;
  logic [15:0]            cfgStart = '0, cfgEnd = '0;
  logic [AW-1:0]          cfgBase = '0;
  logic                   cfgRead = 1'b0, cfgWrite = 1'b0;
  logic                   reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [15:0]            reqAddr = '0, reqWdata = '0;
  logic                   reqReady, rspDone, rspFault;
  logic [15:0]            rspRdata;
  logic [CW-1:0]          cycleCount;

  regmap_mem_port #(.NUM_REGIONS(NR), .MEM_BYTES(MB), .ACCESS_COST(COST), .COUNT_W(CW)) u_regmap_mem_port (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgStart(cfgStart),
    .cfgEnd(cfgEnd), .cfgBase(cfgBase), .cfgRead(cfgRead), .cfgWrite(cfgWrite),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqWord(reqWord),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspDone(rspDone), .rspRdata(rspRdata),
    .rspFault(rspFault), .cycleCount(cycleCount)
  );

  // Bench model
  logic [7:0]    model [MB];
  logic [15:0]   mStart [NR];
  logic [15:0]   mEnd [NR];
  logic [AW-1:0] mBase [NR];
  bit            mRd [NR];
  bit            mWr [NR];
  longint        expCount = 0;
  int            checks = 0;
  int            errors = 0;
  logic [15:0]   lastRd;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic loadWin(input int idx, input logic [15:0] s, input logic [15:0] e,
                         input logic [AW-1:0] b, input bit rd, input bit wr);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx[$clog2(NR)-1:0]; cfgStart = s; cfgEnd = e;
    cfgBase = b; cfgRead = rd; cfgWrite = wr;
    @(posedge clk); #1;
    cfgWe = 1'b0;
    mStart[idx] = s; mEnd[idx] = e; mBase[idx] = b; mRd[idx] = rd; mWr[idx] = wr;
  endtask

  function automatic bit findWin(input logic [15:0] a, input bit wr, output logic [AW-1:0] off);
    off = '0;
    for (int i = 0; i < NR; i++) begin
      if (a >= mStart[i] && a <= mEnd[i] && (wr ? mWr[i] : mRd[i])) begin
        off = mBase[i] + AW'(a - mStart[i]);
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  // One access with full checking against the model
  task automatic access(input bit wr, input bit word, input logic [15:0] a,
                        input logic [15:0] wd, input string req);
    logic [AW-1:0] off;
    bit            hit, bad;
    logic [15:0]   expRd;
    bad = word && a[0];
    hit = findWin(a, wr, off);
    if (bad)       expRd = 16'hFFFF;
    else if (!hit) expRd = word ? 16'hFFFF : 16'h00FF;
    else if (word) expRd = {model[off], model[AW'(off + 1'b1)]};
    else           expRd = {8'h00, model[off]};
    @(negedge clk);
    check(reqReady == 1'b1, "R8", "ready before request", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqWrite = wr; reqWord = word; reqAddr = a; reqWdata = wd;
    @(posedge clk); #1;
    reqValid = 1'b0;
    @(negedge clk);
    check(rspDone == 1'b0 && reqReady == 1'b0, "R8", "busy cycle",
          {30'd0, rspDone, reqReady}, 32'd0);
    @(negedge clk);
    check(rspDone == 1'b1, "R8", "done pulse", {31'd0, rspDone}, 32'd1);
    check(rspFault == bad, {req, " R1"}, "fault flag", {31'd0, rspFault}, {31'd0, bad});
    if (!wr || bad) check(rspRdata == expRd, req, "read data", {16'd0, rspRdata}, {16'd0, expRd});
    lastRd = rspRdata;
    if (wr && hit && !bad) begin
      if (word) begin
        model[off] = wd[15:8];
        model[AW'(off + 1'b1)] = wd[7:0];
      end else begin
        model[off] = wd[7:0];
      end
    end
    expCount += COST;
    @(negedge clk);
    check(rspDone == 1'b0, "R8", "done falls", {31'd0, rspDone}, 32'd0);
    check(cycleCount == CW'(expCount), "R9", "cycle total", cycleCount, expCount[31:0]);
  endtask

  function automatic logic [15:0] fillPat(input int i);
    return {8'(i) ^ 8'h5A, 8'(i >> 1) ^ 8'hC3};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      mStart[i] = '0; mEnd[i] = '0; mBase[i] = '0; mRd[i] = 0; mWr[i] = 0;
    end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state (R11, R9, R8)
    check(reqReady == 1'b1 && rspDone == 1'b0, "R8", "reset handshake",
          {30'd0, reqReady, rspDone}, 32'h2);
    check(cycleCount == '0, "R9", "reset total", cycleCount, 32'd0);
    access(1'b0, 1'b1, 16'h0000, 16'h0, "R11 reset unmapped word");
    access(1'b0, 1'b0, 16'h0003, 16'h0, "R11 reset unmapped byte R5");

    // Fill the whole array through one wide window (R11, R10)
    loadWin(0, 16'h0000, 16'h03FF, '0, 1'b1, 1'b1);
    for (int i = 0; i < MB; i += 2) begin
      access(1'b1, 1'b1, 16'(i), fillPat(i), "R10 fill");
      model[i] = fillPat(i) >> 8;
      model[i + 1] = fillPat(i) & 16'hFF;
    end

    // R2: big-endian layout, literal values
    access(1'b1, 1'b1, 16'h0100, 16'hA1B2, "R2 word write");
    access(1'b0, 1'b0, 16'h0100, 16'h0, "R2 high byte");
    check(lastRd == 16'h00A1, "R2", "lower address is upper byte", {16'd0, lastRd}, 32'h00A1);
    access(1'b0, 1'b0, 16'h0101, 16'h0, "R2 low byte");
    check(lastRd == 16'h00B2, "R2", "next address is lower byte", {16'd0, lastRd}, 32'h00B2);

    // R7: byte write touches one byte only
    access(1'b1, 1'b0, 16'h0101, 16'h77C4, "R7 byte write");
    access(1'b0, 1'b1, 16'h0100, 16'h0, "R7 word after byte write");
    check(lastRd == 16'hA1C4, "R7", "neighbour kept", {16'd0, lastRd}, 32'hA1C4);

    // R1: unaligned word read and write
    access(1'b0, 1'b1, 16'h0101, 16'h0, "R1 odd word read");
    access(1'b1, 1'b1, 16'h0101, 16'hDEAD, "R1 odd word write");
    access(1'b0, 1'b1, 16'h0100, 16'h0, "R1 write dropped");
    check(lastRd == 16'hA1C4, "R1", "array unchanged", {16'd0, lastRd}, 32'hA1C4);

    // R4: inclusive bounds; R10 base offset
    loadWin(0, 16'h0200, 16'h020F, 10'h040, 1'b1, 1'b1);
    access(1'b0, 1'b1, 16'h01FE, 16'h0, "R4 below start R5");
    access(1'b0, 1'b1, 16'h0200, 16'h0, "R4 start R10");
    access(1'b0, 1'b0, 16'h020F, 16'h0, "R4 end");
    access(1'b0, 1'b0, 16'h0210, 16'h0, "R4 past end R5");

    // R3: overlap, read-only window first, read-write second
    loadWin(0, 16'h0300, 16'h03FF, 10'h000, 1'b1, 1'b0);
    loadWin(1, 16'h0300, 16'h03FF, 10'h200, 1'b1, 1'b1);
    access(1'b1, 1'b1, 16'h0310, 16'h5A5A, "R3 write skips read-only");
    access(1'b0, 1'b1, 16'h0310, 16'h0, "R3 read uses first");
    check(lastRd == fillPat(16'h10), "R3", "first window data", {16'd0, lastRd}, {16'd0, fillPat(16'h10)});
    loadWin(2, 16'h0000, 16'h0FFF, 10'h000, 1'b1, 1'b0);
    access(1'b0, 1'b1, 16'h0210, 16'h0, "R3 write landed");
    check(lastRd == 16'h5A5A, "R3", "second window target", {16'd0, lastRd}, 32'h5A5A);

    // R6: no writable window
    loadWin(1, 16'h0000, 16'h0000, 10'h000, 1'b0, 1'b0);
    access(1'b1, 1'b1, 16'h0320, 16'hBEEF, "R6 unwritable write");
    access(1'b0, 1'b1, 16'h0320, 16'h0, "R6 read back");
    check(lastRd == fillPat(16'h20), "R6", "no effect", {16'd0, lastRd}, {16'd0, fillPat(16'h20)});

    // Random windows and accesses
    for (int n = 0; n < 600; n++) begin
      if (n % 40 == 0) begin
        for (int w = 0; w < NR; w++) begin
          logic [15:0] s;
          s = 16'($urandom_range(0, 16'h07FF));
          loadWin(w, s, s + 16'($urandom_range(0, 16'h01FF)), AW'($urandom),
                  1'($urandom), 1'($urandom));
        end
      end
      access(1'($urandom), 1'($urandom), 16'($urandom_range(0, 16'h0FFF)),
             16'($urandom), "R3 R5 R6 R10 random");
    end

    summary();
    $finish;
  end

endmodule